// File: doc/BRIEF.md
# Interleaved Nibble-DRAM Slot Sequencer

This block drives a dynamic RAM array that is four bits wide, from a clock of sixteen sub-cycles per microsecond. Time is cut into access slots of eight sub-cycles. In each slot that holds an access, one row strobe frame carries two column strobes, so one byte moves as two nibbles. The row address and both column addresses share one narrow multiplexed address bus. Read nibbles are joined into a byte. Write bytes are split into nibbles and driven onto the data lines.

Slots go to two requesters: a display fetch port and a processor port. In the shared setting the two alternate slot by slot, so the processor advances at half the slot rate. A second setting gives the processor every slot. A third stops the processor: its slots stay idle while display slots go on. The processor gets a one-cycle clock enable at the end of each slot it owns. The display port gets a one-cycle byte-valid pulse at the end of each of its slots.

Top module: `dram_slot_seq`

## Requirements
- R1: While rst_n is low, both strobes, ram_we_n_o and ram_dq_oe_o are inactive (strobes high, write enable high, drive enable low), and cpu_ce_o and vid_valid_o are low.
- R2: Sub-cycles are counted 0..7 from reset release, so sub-cycle k of slot n is cycle 8n+k. In a slot that holds an access, ram_ras_n_o is low in sub-cycles 1 to 6 and ram_cas_n_o is low in sub-cycles 2, 3, 5 and 6. In an idle slot both stay high.
- R3: ram_a_o carries the row A[15:8] in sub-cycle 1. It carries the column {A[7:1],0} in sub-cycles 2 and 3, and {A[7:1],1} from sub-cycle 4 to 7. A[0] does not reach the RAM, so two addresses that differ only in bit 0 reach the same byte.
- R4: A read byte takes bits [3:0] from ram_dq_i at the end of sub-cycle 3 and bits [7:4] at the end of sub-cycle 6.
- R5: In a processor write slot, ram_we_n_o is low and ram_dq_oe_o is high in sub-cycles 2 to 6. ram_dq_o carries data bits [3:0] in sub-cycles 2 and 3 and bits [7:4] in sub-cycles 4 to 6. In every other slot ram_we_n_o stays high.
- R6: With mode_i = 2'b00, even slots (slot 0 is the first after reset) go to the display port and odd slots go to the processor.
- R7: With mode_i = 2'b01, every slot goes to the processor and vid_valid_o stays low.
- R8: With mode_i = 2'b10 or 2'b11, odd slots are idle: no strobes, no write and no cpu_ce_o. A pending processor write is held back. Even slots still go to the display port.
- R9: cpu_ce_o is high only in sub-cycle 7 of a processor slot, and cpu_rdata_o then holds the byte of that read. vid_valid_o is high only in sub-cycle 7 of a display slot, and vid_data_o then holds its byte. The two pulses are never high together.
- R10: mode_i, both addresses, cpu_we_i and cpu_wdata_i are sampled at the end of sub-cycle 0. Changes later in the slot do not affect that slot's access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-cycle clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | Slot sharing setting |
| cpu_addr_i | input | 16 | Processor byte address |
| cpu_we_i | input | 1 | Processor write request, 1 = write |
| cpu_wdata_i | input | 8 | Processor write byte |
| cpu_ce_o | output | 1 | Processor clock enable pulse |
| cpu_rdata_o | output | 8 | Byte from the last processor read |
| vid_addr_i | input | 16 | Display fetch byte address |
| vid_valid_o | output | 1 | Display byte-valid pulse |
| vid_data_o | output | 8 | Byte from the last display fetch |
| ram_a_o | output | 8 | Multiplexed row/column address |
| ram_ras_n_o | output | 1 | Row strobe, active low |
| ram_cas_n_o | output | 1 | Column strobe, active low |
| ram_we_n_o | output | 1 | Write enable, 0 = write, 1 = read |
| ram_dq_o | output | 4 | Write nibble to the RAM |
| ram_dq_oe_o | output | 1 | Drive enable for ram_dq_o |
| ram_dq_i | input | 4 | Read nibble from the RAM |

## Verification
Requests are sampled at the end of sub-cycle 0. Their strobes and addresses show from sub-cycle 1, and their result and pulse are due in sub-cycle 7 of the same slot, seven cycles after sampling. The bench keeps a cycle index from reset release and predicts every strobe, address, nibble and pulse for that exact sub-cycle. It compares them at each falling edge, so the design's registers have settled. A behavioural nibble RAM in the bench answers the strobes, and a byte shadow predicts each read. Addresses are disturbed in the middle of some slots and restored before the slot's end. This shows that only the values sampled at sub-cycle 0 are used.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int SUB_N = 8;
  localparam int SUB_W = $clog2(SUB_N);

  localparam logic [SUB_W-1:0] SUB_LATCH   = SUB_W'(0);
  localparam logic [SUB_W-1:0] SUB_RAS_ON  = SUB_W'(1);
  localparam logic [SUB_W-1:0] SUB_CAS1_ON = SUB_W'(2);
  localparam logic [SUB_W-1:0] SUB_CAP_LO  = SUB_W'(3);
  localparam logic [SUB_W-1:0] SUB_COL2    = SUB_W'(4);
  localparam logic [SUB_W-1:0] SUB_CAS2_ON = SUB_W'(5);
  localparam logic [SUB_W-1:0] SUB_CAP_HI  = SUB_W'(6);
  localparam logic [SUB_W-1:0] SUB_LAST    = SUB_W'(SUB_N - 1);

  localparam logic [1:0] MODE_SHARED  = 2'b00;
  localparam logic [1:0] MODE_CPU_ALL = 2'b01;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_VID  = 2'd1,
    SLOT_CPU  = 2'd2
  } slot_kind_e;

  // row strobe frame: sub-cycles 1..6
  function automatic logic ras_low(input logic [SUB_W-1:0] s);
    return (s >= SUB_RAS_ON) && (s <= SUB_CAP_HI);
  endfunction

  // two column strobes: 2..3 and 5..6
  function automatic logic cas_low(input logic [SUB_W-1:0] s);
    return ((s >= SUB_CAS1_ON) && (s < SUB_COL2)) ||
           ((s >= SUB_CAS2_ON) && (s <= SUB_CAP_HI));
  endfunction

  function automatic logic second_nibble(input logic [SUB_W-1:0] s);
    return s >= SUB_COL2;
  endfunction

  function automatic logic write_window(input logic [SUB_W-1:0] s);
    return (s >= SUB_CAS1_ON) && (s <= SUB_CAP_HI);
  endfunction

  function automatic slot_kind_e pick_kind(input logic [1:0] mode, input logic odd);
    if (mode == MODE_CPU_ALL) return SLOT_CPU;
    if (!odd)                 return SLOT_VID;
    if (mode == MODE_SHARED)  return SLOT_CPU;
    return SLOT_IDLE;
  endfunction

endpackage

// File: rtl/dram_seq_phase.sv
module dram_seq_phase
  import dram_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [SUB_W-1:0] sub_o,
  output logic             odd_o,
  output logic             latch_evt_o,
  output logic             end_evt_o
);

  logic [SUB_W-1:0] sub_q;
  logic             odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= SUB_LATCH;
      odd_q <= 1'b0;
    end else begin
      sub_q <= (sub_q == SUB_LAST) ? SUB_LATCH : sub_q + SUB_W'(1);
      if (sub_q == SUB_LATCH) odd_q <= ~odd_q;
    end
  end

  assign sub_o       = sub_q;
  assign odd_o       = odd_q;
  assign latch_evt_o = (sub_q == SUB_LATCH);
  assign end_evt_o   = (sub_q == SUB_LAST);

endmodule

// File: rtl/dram_seq_arbiter.sv
module dram_seq_arbiter
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_evt_i,
  input  logic              odd_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic [ADDR_W-1:0] vid_addr_i,
  output slot_kind_e        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);

  slot_kind_e next_kind;
  assign next_kind = pick_kind(mode_i, odd_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_o  <= SLOT_IDLE;
      addr_o  <= '0;
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else if (latch_evt_i) begin
      kind_o  <= next_kind;
      addr_o  <= (next_kind == SLOT_CPU) ? cpu_addr_i : vid_addr_i;
      we_o    <= (next_kind == SLOT_CPU) && cpu_we_i;
      wdata_o <= cpu_wdata_i;
    end
  end

endmodule

// File: rtl/dram_seq_datapath.sv
module dram_seq_datapath
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int RA_W  = ADDR_W / 2,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SUB_W-1:0]  sub_i,
  input  slot_kind_e        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NIB_W-1:0]  ram_dq_i,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [RA_W-1:0]   ram_a_o,
  output logic [NIB_W-1:0]  ram_dq_o,
  output logic              ram_dq_oe_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [DATA_W-1:0] vid_data_o
);

  logic             access;
  logic             drive;
  logic             cap_lo_evt;
  logic             cap_hi_evt;
  logic             lsb_unused;
  logic [NIB_W-1:0] lo_q;

  assign access     = (kind_i != SLOT_IDLE);
  assign drive      = access && (kind_i == SLOT_CPU) && we_i && write_window(sub_i);
  assign cap_lo_evt = access && (sub_i == SUB_CAP_LO);
  assign cap_hi_evt = access && (sub_i == SUB_CAP_HI);
  assign lsb_unused = addr_i[0];

  assign ras_n_o     = !(access && ras_low(sub_i));
  assign cas_n_o     = !(access && cas_low(sub_i));
  assign we_n_o      = !drive;
  assign ram_dq_oe_o = drive;
  assign ram_a_o     = (sub_i <= SUB_RAS_ON) ? addr_i[ADDR_W-1 -: RA_W]
                                             : {addr_i[RA_W-1:1], second_nibble(sub_i)};
  assign ram_dq_o    = second_nibble(sub_i) ? wdata_i[DATA_W-1 -: NIB_W]
                                            : wdata_i[NIB_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q        <= '0;
      cpu_rdata_o <= '0;
      vid_data_o  <= '0;
    end else begin
      if (cap_lo_evt) lo_q <= ram_dq_i;
      if (cap_hi_evt && kind_i == SLOT_VID) vid_data_o <= {ram_dq_i, lo_q};
      if (cap_hi_evt && kind_i == SLOT_CPU && !we_i) cpu_rdata_o <= {ram_dq_i, lo_q};
    end
  end

endmodule

// File: rtl/dram_slot_seq.sv
module dram_slot_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int RA_W  = ADDR_W / 2,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ce_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic [ADDR_W-1:0] vid_addr_i,
  output logic              vid_valid_o,
  output logic [DATA_W-1:0] vid_data_o,
  output logic [RA_W-1:0]   ram_a_o,
  output logic              ram_ras_n_o,
  output logic              ram_cas_n_o,
  output logic              ram_we_n_o,
  output logic [NIB_W-1:0]  ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [NIB_W-1:0]  ram_dq_i
);

  logic [SUB_W-1:0]  sub;
  logic              odd;
  logic              latch_evt;
  logic              end_evt;
  slot_kind_e        kind;
  logic [ADDR_W-1:0] slot_addr;
  logic              slot_we;
  logic [DATA_W-1:0] slot_wdata;

  dram_seq_phase u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .sub_o       (sub),
    .odd_o       (odd),
    .latch_evt_o (latch_evt),
    .end_evt_o   (end_evt)
  );

  dram_seq_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_evt_i (latch_evt),
    .odd_i       (odd),
    .mode_i      (mode_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_wdata_i (cpu_wdata_i),
    .vid_addr_i  (vid_addr_i),
    .kind_o      (kind),
    .addr_o      (slot_addr),
    .we_o        (slot_we),
    .wdata_o     (slot_wdata)
  );

  dram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .sub_i       (sub),
    .kind_i      (kind),
    .addr_i      (slot_addr),
    .we_i        (slot_we),
    .wdata_i     (slot_wdata),
    .ram_dq_i    (ram_dq_i),
    .ras_n_o     (ram_ras_n_o),
    .cas_n_o     (ram_cas_n_o),
    .we_n_o      (ram_we_n_o),
    .ram_a_o     (ram_a_o),
    .ram_dq_o    (ram_dq_o),
    .ram_dq_oe_o (ram_dq_oe_o),
    .cpu_rdata_o (cpu_rdata_o),
    .vid_data_o  (vid_data_o)
  );

  assign cpu_ce_o    = end_evt && (kind == SLOT_CPU);
  assign vid_valid_o = end_evt && (kind == SLOT_VID);

endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker #(
  parameter int RA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            dq_oe,
  input logic [RA_W-1:0] ram_a,
  input logic            cpu_ce,
  input logic            vid_valid,
  input logic            slot_start,
  input logic            slot_end
);

  logic [1:0] cas_falls;
  logic       cas_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_falls <= 2'd0;
      cas_prev  <= 1'b1;
    end else begin
      cas_prev <= cas_n;
      if (ras_n)                  cas_falls <= 2'd0;
      else if (!cas_n && cas_prev) cas_falls <= cas_falls + 2'd1;
    end
  end

  AST_CAS_INSIDE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n); // R2

  AST_TWO_COLUMNS_PER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_falls == 2'd2); // R2

  AST_IDLE_AT_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> (ras_n && cas_n && we_n)); // R2

  AST_SLOT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> slot_start); // R2

  AST_ADDR_HELD_UNDER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(ram_a)); // R3

  AST_WRITE_INSIDE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ras_n && dq_oe)); // R5

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ce && vid_valid)); // R9

  AST_PULSE_AT_SLOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce || vid_valid) |-> slot_end); // R9

endmodule

bind dram_slot_seq dram_seq_checker #(.RA_W(RA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n      (ram_ras_n_o),
  .cas_n      (ram_cas_n_o),
  .we_n       (ram_we_n_o),
  .dq_oe      (ram_dq_oe_o),
  .ram_a      (ram_a_o),
  .cpu_ce     (cpu_ce_o),
  .vid_valid  (vid_valid_o),
  .slot_start (latch_evt),
  .slot_end   (end_evt)
);

// File: tb/test_dram_slot_seq.sv
module test_dram_slot_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] cpu_addr = 16'h0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = 8'h0;
  logic        cpu_ce;
  logic [7:0]  cpu_rdata;
  logic [15:0] vid_addr = 16'h0;
  logic        vid_valid;
  logic [7:0]  vid_data;
  logic [7:0]  ram_a;
  logic        ras_n, cas_n, we_n, dq_oe;
  logic [3:0]  dq_out;
  logic [3:0]  dq_drv = 4'h0;

  always #10 clk = ~clk;

  dram_slot_seq i_dram_slot_seq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .cpu_addr_i(cpu_addr), .cpu_we_i(cpu_we), .cpu_wdata_i(cpu_wdata),
    .cpu_ce_o(cpu_ce), .cpu_rdata_o(cpu_rdata),
    .vid_addr_i(vid_addr), .vid_valid_o(vid_valid), .vid_data_o(vid_data),
    .ram_a_o(ram_a), .ram_ras_n_o(ras_n), .ram_cas_n_o(cas_n), .ram_we_n_o(we_n),
    .ram_dq_o(dq_out), .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_drv)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural nibble RAM answering the strobes
  bit [3:0] cells [int];
  bit [7:0] shadow [int];
  logic [7:0] row_l = 8'h0, col_l = 8'h0;
  logic ras_p = 1'b1, cas_p = 1'b1;

  function automatic logic [3:0] cell_init(input logic [7:0] r, input logic [7:0] c);
    return r[3:0] ^ c[3:0] ^ c[7:4] ^ 4'h6;
  endfunction

  always @(negedge clk) begin
    if (!ras_n && ras_p) row_l = ram_a;
    if (!cas_n && cas_p) begin
      col_l = ram_a;
      if (!we_n) cells[int'({row_l, col_l})] = dq_out;
    end
    if (!cas_n)
      dq_drv = cells.exists(int'({row_l, col_l})) ? cells[int'({row_l, col_l})]
                                                  : cell_init(row_l, col_l);
    ras_p = ras_n;
    cas_p = cas_n;
  end

  function automatic logic [7:0] exp_byte(input logic [15:0] a);
    if (shadow.exists(int'(a[15:1]))) return shadow[int'(a[15:1])];
    return {cell_init(a[15:8], {a[7:1], 1'b1}), cell_init(a[15:8], {a[7:1], 1'b0})};
  endfunction

  // 0 idle, 1 display, 2 processor
  function automatic int owner(input logic [1:0] m, input int slot);
    if (m == 2'b01) return 2;
    if (slot % 2 == 0) return 1;
    return (m == 2'b00) ? 2 : 0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int cpu_i = 0;
  int vid_i = 0;

  task automatic next_cpu();
    cpu_i++;
    cpu_addr  = 16'h3000 + 16'(cpu_i % 6) * 16'h0122;
    cpu_we    = (cpu_i % 4 == 1);
    cpu_wdata = 8'(cpu_i * 37 + 5);
  endtask

  task automatic next_vid();
    vid_i++;
    vid_addr = (vid_i % 4 == 0) ? 16'h3000 + 16'(vid_i % 6) * 16'h0122
                                : 16'h5800 + 16'(vid_i * 2);
  endtask

  int          kind = 0;
  logic [15:0] s_addr;
  logic        s_we;
  logic [7:0]  s_wd;
  logic [15:0] sv_cpu, sv_vid;
  logic        sv_we;
  logic [7:0]  sv_wd;

  task automatic step(input int cyc);
    int sc;
    int slot;
    bit acc;
    bit wr;
    string mtag;
    string atag;
    sc   = cyc % 8;
    slot = cyc / 8;
    if (sc == 0) begin
      kind   = owner(mode, slot);
      s_addr = (kind == 2) ? cpu_addr : vid_addr;
      s_we   = (kind == 2) && cpu_we;
      s_wd   = cpu_wdata;
    end
    acc  = (kind != 0);
    wr   = s_we && sc >= 2 && sc <= 6;
    mtag = (mode == 2'b00) ? "R6" : (mode == 2'b01) ? "R7" : "R8";
    atag = (slot % 4 == 1) ? "R10" : "R3";
    check("R2", "ras_n", 32'(ras_n), 32'(!(acc && sc >= 1 && sc <= 6)));
    check("R2", "cas_n", 32'(cas_n), 32'(!(acc && (sc == 2 || sc == 3 || sc == 5 || sc == 6))));
    check("R5", "we_n", 32'(we_n), 32'(!wr));
    check("R5", "dq_oe", 32'(dq_oe), 32'(wr));
    if (wr) check("R5", "dq_out", 32'(dq_out), 32'((sc >= 4) ? s_wd[7:4] : s_wd[3:0]));
    if (acc && sc >= 1)
      check(atag, "ram_a", 32'(ram_a),
            32'((sc == 1) ? s_addr[15:8] : {s_addr[7:1], (sc >= 4) ? 1'b1 : 1'b0}));
    check(mtag, "cpu_ce", 32'(cpu_ce), 32'(kind == 2 && sc == 7));
    check(mtag, "vid_valid", 32'(vid_valid), 32'(kind == 1 && sc == 7));
    // R10: disturb every input of the slot after sampling, restore before its end
    if (sc == 2 && slot % 4 == 1) begin
      sv_cpu = cpu_addr; sv_vid = vid_addr; sv_we = cpu_we; sv_wd = cpu_wdata;
      cpu_addr = ~cpu_addr; vid_addr = ~vid_addr; cpu_we = ~cpu_we; cpu_wdata = ~cpu_wdata;
    end
    if (sc == 5 && slot % 4 == 1) begin
      cpu_addr = sv_cpu; vid_addr = sv_vid; cpu_we = sv_we; cpu_wdata = sv_wd;
    end
    if (sc == 3) begin
      if (slot < 40)       mode = 2'b00;
      else if (slot < 80)  mode = 2'b01;
      else if (slot < 100) mode = 2'b10;
      else if (slot < 110) mode = 2'b11;
      else                 mode = 2'b00;
    end
    if (sc == 7) begin
      if (kind == 2) begin
        if (s_we) shadow[int'(s_addr[15:1])] = s_wd;
        else check("R4", "cpu_rdata R9", 32'(cpu_rdata), 32'(exp_byte(s_addr)));
        next_cpu();
      end else if (kind == 1) begin
        check("R4", "vid_data R9", 32'(vid_data), 32'(exp_byte(s_addr)));
        next_vid();
      end
    end
  endtask

  initial begin
    next_cpu();
    next_vid();
    repeat (4) begin
      @(negedge clk);
      check("R1", "ras_n", 32'(ras_n), 32'd1);
      check("R1", "cas_n", 32'(cas_n), 32'd1);
      check("R1", "we_n", 32'(we_n), 32'd1);
      check("R1", "dq_oe", 32'(dq_oe), 32'd0);
      check("R1", "cpu_ce", 32'(cpu_ce), 32'd0);
      check("R1", "vid_valid", 32'(vid_valid), 32'd0);
    end
    rst_n = 1'b1;
    step(0);
    for (int c = 1; c < 1120; c++) begin
      @(negedge clk);
      step(c);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule